// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Synchronous Rectification

This block turns the drive request of a winding chopper into the four gate enables of one H-bridge. There is one high-side switch and one low-side switch on each of legs A and B. The chopper reports one of four modes: idle, drive, slow decay or fast decay. A polarity bit gives the wanted current direction. The block decodes that request into a target switch pattern. It then walks to that pattern through a small state machine, which never turns a switch on without first holding the whole bridge off for a programmable number of cycles.

During decay the block can turn on the switches that carry the recirculating current, so that the current does not flow through body diodes. This synchronous rectification is active while `sr_off` is low. When `zero_cur` reports that the winding current has reached zero during a decay period with rectification active, the block shuts the bridge off. The bridge stays off until the chopper next requests drive, so the winding current can never reverse through a rectifying switch. Pulling `out_en` low forces all switches off at once.

Sequencer states:
- `ST_OFF`: all switches off.
- `ST_DEAD`: all switches off while the dead-time counter runs.
- `ST_ON`: the stored pattern drives the gates.

Transitions:
- OFF→DEAD: a non-empty target appears.
- DEAD→ON: the counter expires and the latest target is loaded.
- DEAD→OFF: the target empties.
- ON→DEAD: the target changes to another non-empty pattern.
- ON→OFF: the target empties.

Top module: `hbridge_gate_seq`

## Requirements
- R1: After reset all four gate outputs are low.
- R2: In drive mode (`chop_mode`=1), polarity 0 turns on high-A and low-B, and polarity 1 turns on low-A and high-B.
- R3: In slow decay (`chop_mode`=2) with `sr_off` low, both low-side switches are on, whatever the polarity.
- R4: In fast decay (`chop_mode`=3) with `sr_off` low, the reverse diagonal is on: low-A and high-B for polarity 0, high-A and low-B for polarity 1.
- R5: With `sr_off` high, slow decay keeps only the low side of the driven diagonal (low-B for polarity 0, low-A for polarity 1), and fast decay turns all switches off.
- R6: Before any new non-empty pattern is applied, all gates are held low for max(`dead_cycles`,1) clock cycles. This holds for every pattern change, including entry into and exit from decay and a polarity flip. The new pattern appears on the following cycle.
- R7: High and low switches of the same leg are never on in the same cycle.
- R8: With `out_en` low, all gates are low from the cycle after the clock edge that samples it, with no dead time on the way down.
- R9: A `zero_cur` sampled high during decay with `sr_off` low turns all gates off in the next cycle. They stay off, even after `zero_cur` falls, until drive mode is requested again.
- R10: With `sr_off` high, `zero_cur` is ignored and the decay pattern is kept.
- R11: Idle mode (`chop_mode`=0) turns all gates off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chop_mode | input | 2 | Chopper request: 0 idle, 1 drive, 2 slow decay, 3 fast decay |
| polarity | input | 1 | Winding current direction: 0 from A to B, 1 from B to A |
| sr_off | input | 1 | High disables synchronous rectification |
| zero_cur | input | 1 | Winding current has reached zero |
| out_en | input | 1 | Low forces all switches off |
| dead_cycles | input | DT_W | Dead-time length in clock cycles (0 acts as 1) |
| gate_hi_a | output | 1 | High-side switch, leg A |
| gate_lo_a | output | 1 | Low-side switch, leg A |
| gate_hi_b | output | 1 | High-side switch, leg B |
| gate_lo_b | output | 1 | Low-side switch, leg B |

## Verification
The bench builds the block with the default `DT_W` of 6. It drives `dead_cycles` at 3, 2 and 0, which covers a multi-cycle window, a short window and the zero-means-one floor. Every mode, polarity and rectification combination in the vector table passes through a full dead window from the off state. The directed cases then reach the transitions that do not start from off: drive into decay, a polarity flip, zero-current cutoff and its release, and an enable drop.

// File: rtl/hgs_pkg.sv
package hgs_pkg;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_DRIVE = 2'd1,
        CH_SLOW  = 2'd2,
        CH_FAST  = 2'd3
    } chop_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_DEAD = 2'd1,
        ST_ON   = 2'd2
    } seq_e;

    // Bit order: hi_a, lo_a, hi_b, lo_b
    typedef struct packed {
        logic hi_a;
        logic lo_a;
        logic hi_b;
        logic lo_b;
    } gates_t;

    localparam gates_t GATES_OFF = '0;
endpackage

// File: rtl/hgs_pattern.sv
module hgs_pattern
    import hgs_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       polarity,
    input  logic       sr_off,
    input  logic       out_en,
    input  logic       zero_kill,
    output gates_t     target
);
    always_comb begin
        target = GATES_OFF;
        if (out_en && !zero_kill) begin
            unique case (chop_e'(mode))
                CH_IDLE:  target = GATES_OFF;
                CH_DRIVE: begin
                    target.hi_a = !polarity;
                    target.lo_b = !polarity;
                    target.lo_a = polarity;
                    target.hi_b = polarity;
                end
                CH_SLOW: begin
                    // rectifying: both lows; diode-only: keep driven low side
                    target.lo_a = !sr_off || polarity;
                    target.lo_b = !sr_off || !polarity;
                end
                CH_FAST: begin
                    if (!sr_off) begin
                        target.lo_a = !polarity;
                        target.hi_b = !polarity;
                        target.hi_a = polarity;
                        target.lo_b = polarity;
                    end
                end
            endcase
        end
    end

    always_comb begin
        assert (!(target.hi_a && target.lo_a) && !(target.hi_b && target.lo_b))
            else $error("a_r7_target_legs: decoded pattern shorts a leg");
    end
endmodule

// File: rtl/hgs_zero_hold.sv
module hgs_zero_hold
    import hgs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       sr_off,
    input  logic       zero_cur,
    output logic       zero_kill,
    output logic       held
);
    logic in_decay;
    logic fresh_zero;

    assign in_decay   = (chop_e'(mode) == CH_SLOW) || (chop_e'(mode) == CH_FAST);
    assign fresh_zero = in_decay && zero_cur && !sr_off;
    assign zero_kill  = in_decay && (held || fresh_zero);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (chop_e'(mode) == CH_DRIVE) begin
            held <= 1'b0;
        end else if (fresh_zero) begin
            held <= 1'b1;
        end
    end

    // R9: once latched, the hold survives until a drive request
    a_r9_hold_until_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (held && chop_e'(mode) != CH_DRIVE) |=> held);
endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
    import hgs_pkg::*;
#(
    parameter int DT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      chop_mode,
    input  logic            polarity,
    input  logic            sr_off,
    input  logic            zero_cur,
    input  logic            out_en,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            gate_hi_a,
    output logic            gate_lo_a,
    output logic            gate_hi_b,
    output logic            gate_lo_b
);
    localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

    gates_t          target;
    gates_t          cur_q, cur_d;
    gates_t          gates;
    seq_e            state_q, state_d;
    logic [DT_W-1:0] cnt_q, cnt_d;
    logic            zero_kill;
    logic            zero_held;

    hgs_zero_hold u_zero (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (chop_mode),
        .sr_off    (sr_off),
        .zero_cur  (zero_cur),
        .zero_kill (zero_kill),
        .held      (zero_held)
    );

    hgs_pattern u_pattern (
        .mode      (chop_mode),
        .polarity  (polarity),
        .sr_off    (sr_off),
        .out_en    (out_en),
        .zero_kill (zero_kill),
        .target    (target)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OFF: begin
                if (target != GATES_OFF) begin
                    state_d = ST_DEAD;
                    cnt_d   = CNT_ONE;
                end
            end
            ST_DEAD: begin
                if (target == GATES_OFF) begin
                    state_d = ST_OFF;
                end else if (cnt_q >= dead_cycles) begin
                    state_d = ST_ON;
                    cur_d   = target;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            ST_ON: begin
                if (target != cur_q) begin
                    if (target == GATES_OFF) begin
                        state_d = ST_OFF;
                    end else begin
                        state_d = ST_DEAD;
                        cnt_d   = CNT_ONE;
                    end
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cur_q   <= GATES_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        gates = (state_q == ST_ON) ? cur_q : GATES_OFF;
    end

    assign gate_hi_a = gates.hi_a;
    assign gate_lo_a = gates.lo_a;
    assign gate_hi_b = gates.hi_b;
    assign gate_lo_b = gates.lo_b;

    a_r7_leg_a: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_a && gate_lo_a));
    a_r7_leg_b: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_b && gate_lo_b));
    a_r6_off_before_on: assert property (@(posedge clk) disable iff (!rst_n)
        ((gates & ~$past(gates)) != GATES_OFF) |-> ($past(gates) == GATES_OFF));
    a_r8_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> (gates == GATES_OFF));
    a_r9_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        zero_held |-> (gates == GATES_OFF));
endmodule

// File: tb/hbridge_gate_seq_tb.sv
module hbridge_gate_seq_tb;
    localparam int DT_W = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      chop_mode = 2'd0;
    logic            polarity = 1'b0;
    logic            sr_off = 1'b0;
    logic            zero_cur = 1'b0;
    logic            out_en = 1'b1;
    logic [DT_W-1:0] dead_cycles = DT_W'(3);
    logic            gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hbridge_gate_seq #(.DT_W(DT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .chop_mode(chop_mode), .polarity(polarity),
        .sr_off(sr_off), .zero_cur(zero_cur), .out_en(out_en),
        .dead_cycles(dead_cycles), .gate_hi_a(gate_hi_a), .gate_lo_a(gate_lo_a),
        .gate_hi_b(gate_hi_b), .gate_lo_b(gate_lo_b)
    );

    // Vector: {mode[1:0], polarity, sr_off, out_en, expected {hi_a,lo_a,hi_b,lo_b}}
    localparam int NV = 12;
    localparam logic [8:0] VECS [NV] = '{
        9'b01_0_0_1_1001, 9'b01_1_0_1_0110, 9'b01_0_1_1_1001,
        9'b10_0_0_1_0101, 9'b10_1_0_1_0101, 9'b10_0_1_1_0001,
        9'b10_1_1_1_0100, 9'b11_0_0_1_0110, 9'b11_1_0_1_1001,
        9'b11_0_1_1_0000, 9'b00_0_0_1_0000, 9'b01_0_0_0_0000
    };

    function automatic logic [3:0] gates_now();
        return {gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b};
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = gates_now();
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: gates=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // After inputs change at a negedge: n dead cycles of all-off, then the pattern.
    task automatic expect_dead(input int n, input logic [3:0] exp, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R6 dead window", 4'b0000);
        end
        @(negedge clk);
        check(req, exp);
    endtask

    function automatic string vec_req(input logic [1:0] m, input logic so, input logic en);
        if (!en) return "R8 disabled";
        case (m)
            2'd0: return "R11 idle";
            2'd1: return "R2 drive";
            2'd2: return so ? "R5 slow no-rect" : "R3 slow rect";
            default: return so ? "R5 fast no-rect" : "R4 fast rect";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", 4'b0000);

        // Vector table: each from idle, dead time 3
        for (int v = 0; v < NV; v++) begin
            chop_mode = 2'd0; out_en = 1'b1; sr_off = 1'b0; polarity = 1'b0;
            repeat (3) @(negedge clk);
            chop_mode = VECS[v][8:7];
            polarity  = VECS[v][6];
            sr_off    = VECS[v][5];
            out_en    = VECS[v][4];
            expect_dead(3, VECS[v][3:0], vec_req(VECS[v][8:7], VECS[v][5], VECS[v][4]));
        end

        // Drive to slow decay, dead time 2
        chop_mode = 2'd0; out_en = 1'b1; sr_off = 1'b0; polarity = 1'b0;
        dead_cycles = DT_W'(2);
        repeat (3) @(negedge clk);
        chop_mode = 2'd1;
        expect_dead(2, 4'b1001, "R2 drive pol0");
        chop_mode = 2'd2;
        expect_dead(2, 4'b0101, "R6 entry into decay");

        // Zero current with rectification active
        zero_cur = 1'b1;
        @(negedge clk);
        check("R9 zero cutoff", 4'b0000);
        zero_cur = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 zero hold", 4'b0000);
        chop_mode = 2'd1;
        expect_dead(2, 4'b1001, "R9 release on drive");

        // Polarity flip in drive
        polarity = 1'b1;
        expect_dead(2, 4'b0110, "R6 polarity flip");

        // Slow decay without rectification, zero ignored
        polarity = 1'b0; sr_off = 1'b1; chop_mode = 2'd2;
        expect_dead(2, 4'b0001, "R5 slow no-rect");
        zero_cur = 1'b1;
        @(negedge clk);
        check("R10 zero ignored", 4'b0001);
        repeat (2) @(negedge clk);
        check("R10 zero ignored later", 4'b0001);
        zero_cur = 1'b0;

        // Enable drop: off next cycle
        out_en = 1'b0;
        @(negedge clk);
        check("R8 disable", 4'b0000);
        out_en = 1'b1;
        expect_dead(2, 4'b0001, "R6 restart after enable");

        // Zero dead-cycle setting acts as one
        dead_cycles = '0;
        sr_off = 1'b0; chop_mode = 2'd1;
        expect_dead(1, 4'b1001, "R6 zero setting floor");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule